// File: doc/BRIEF.md
# I2C Burst Receive Controller

This block is the receive half of an I2C master. One write of an 8-bit control word starts a burst. The low seven bits of the word give the number of bytes to read. The top bit decides how the last byte of the burst is answered. The block then runs the SCL clock, shifts in each byte most-significant bit first, and gives the ninth clock of every byte to an acknowledge slot. Each received byte goes into an on-chip receive FIFO.

Software takes bytes out of the FIFO one per pop strobe, reading the oldest byte on a show-ahead data port. A sticky completion flag, with an optional interrupt, reports the end of the burst. A read longer than one FIFO is split into several bursts. Every burst except the final one is issued with the NAK bit clear, so all of its bytes are acknowledged and the target keeps sending. Only the final burst sets the bit and ends in NAK.

Address phase, START/STOP generation and transmission belong to neighbouring logic and are not handled here. SCL and SDA are driven open-drain style: `scl_o` high means released, and `sda_drive_low` high means the block pulls SDA low.

Top module: `i2c_burst_rx`

## Requirements
- R1: After reset `busy`=0, `rx_empty`=1, `done_flag`=0, `irq`=0, `scl_o`=1 and `sda_drive_low`=0. Whenever `busy` is 0, SCL and SDA are both released.
- R2: A `ctl_wr` accepted while `busy`=0 starts a burst. `ctl_data[6:0]` is the byte count and `ctl_data[7]` is the NAK-last enable. A count above FIFO_DEPTH (default 64) is clamped to FIFO_DEPTH. `busy` rises only after such a write.
- R3: Each byte takes nine SCL clocks. SCL is low for SCL_HALF cycles, then high for SCL_HALF cycles. Data bits are sampled MSB first in the last cycle of the high phase. After the final byte, SCL gives one more low phase before it is released, so a burst of N bytes makes 9*N+1 SCL falling edges. `sda_drive_low` never changes while SCL stays high.
- R4: On the ninth clock of a byte the block acknowledges by holding `sda_drive_low`=1. When the NAK-last enable is 1, the last byte of the burst is not acknowledged (`sda_drive_low`=0). All earlier bytes are acknowledged.
- R5: When the NAK-last enable is 0, every byte of the burst is acknowledged, the last one included.
- R6: Received bytes leave the FIFO in arrival order. `pop_data` shows the oldest byte, `pop` removes it, and `rx_empty`=1 when no byte is held. A `pop` while empty has no effect.
- R7: `done_flag` is set when a burst completes and stays set until `done_clr`. `irq` is `done_flag` gated by `irq_en`.
- R8: A count of 0 sets `done_flag` on the clock edge that accepts the write. It produces no SCL edge and leaves `busy` low.
- R9: A `ctl_wr` while `busy`=1 is ignored. The running burst keeps its count and NAK setting.
- R10: A byte that arrives while the FIFO holds FIFO_DEPTH bytes is discarded. The bus still clocks and acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_data | input | 8 | Control word: [6:0] count, [7] NAK-last enable |
| busy | output | 1 | Burst in progress (including the final SCL low phase) |
| pop | input | 1 | Remove the oldest FIFO byte |
| pop_data | output | 8 | Oldest FIFO byte (show-ahead) |
| rx_empty | output | 1 | FIFO holds no byte |
| done_flag | output | 1 | Sticky burst-complete flag |
| done_clr | input | 1 | Clears `done_flag` |
| irq_en | input | 1 | Interrupt enable for completion |
| irq | output | 1 | Completion interrupt |
| scl_o | output | 1 | SCL: 1 released, 0 driven low |
| sda_drive_low | output | 1 | 1 pulls SDA low (ACK) |
| sda_i | input | 1 | Sampled SDA line |

## Verification
The assertions check, on every cycle, the rules that hold at any time. The bus must be released while idle, and SDA may not move during an SCL high phase. ACK drive may appear only inside a burst, and a burst may start only after a control write. A zero-count write must complete on the next edge. The completion flag must rise only through a burst or a write, and fall only through a clear. Only the bench scenarios can show the data order, the exact ACK/NAK pattern per byte and the SCL edge count per burst. The same holds for the clamp at 64, dropping into a full FIFO, and ignoring a write during a busy burst. The bench shows these by driving a modelled target and draining the FIFO.

// File: rtl/i2c_brx_pkg.sv
package i2c_brx_pkg;

    localparam int CNT_W  = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_LOW  = 2'd1,
        ENG_HIGH = 2'd2,
        ENG_TAIL = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic             nak_last;
        logic [CNT_W-1:0] count;
    } rx_ctl_t;

    // Limit a requested count to the largest burst the FIFO can hold.
    function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] req,
                                                     input int lim);
        if (int'(req) > lim) return CNT_W'(lim);
        return req;
    endfunction

endpackage

// File: rtl/i2c_brx_fifo.sv
module i2c_brx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    assign empty   = (fill == '0);
    assign full    = (fill == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        return p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/i2c_brx_bit_eng.sv
module i2c_brx_bit_eng
    import i2c_brx_pkg::*;
#(
    parameter int HALF = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cont,
    input  logic              ack_en,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_low,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_q,
    output logic              idle
);
    localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(HALF - 1);
    localparam logic [3:0]    ACK_SLOT = 4'd8;

    eng_state_e        state;
    logic [TW-1:0]     tmr;
    logic [3:0]        bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic              phase_end;

    assign phase_end = (tmr == T_LAST);
    assign idle      = (state == ENG_IDLE);
    assign scl_o     = (state == ENG_IDLE) || (state == ENG_HIGH);
    assign sda_low   = ((state == ENG_LOW) || (state == ENG_HIGH)) &&
                       (bit_idx == ACK_SLOT) && ack_en;
    assign byte_done = (state == ENG_HIGH) && phase_end && (bit_idx == ACK_SLOT);
    assign byte_q    = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ENG_IDLE;
            tmr     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (start) begin
                        state   <= ENG_LOW;
                        tmr     <= '0;
                        bit_idx <= '0;
                    end
                end
                ENG_LOW: begin
                    if (phase_end) begin
                        tmr   <= '0;
                        state <= ENG_HIGH;
                    end else begin
                        tmr <= tmr + TW'(1);
                    end
                end
                ENG_HIGH: begin
                    if (phase_end) begin
                        tmr <= '0;
                        if (bit_idx != ACK_SLOT) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_i};
                            bit_idx <= bit_idx + 4'd1;
                            state   <= ENG_LOW;
                        end else if (cont) begin
                            bit_idx <= '0;
                            state   <= ENG_LOW;
                        end else begin
                            bit_idx <= '0;
                            state   <= ENG_TAIL;
                        end
                    end else begin
                        tmr <= tmr + TW'(1);
                    end
                end
                ENG_TAIL: begin
                    if (phase_end) begin
                        tmr   <= '0;
                        state <= ENG_IDLE;
                    end else begin
                        tmr <= tmr + TW'(1);
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_brx_seq.sv
module i2c_brx_seq
    import i2c_brx_pkg::*;
#(
    parameter int MAX_BURST = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ctl_wr,
    input  rx_ctl_t ctl_word,
    input  logic    eng_idle,
    input  logic    byte_done,
    output logic    eng_start,
    output logic    eng_cont,
    output logic    eng_ack_en,
    output logic    push,
    output logic    done_set,
    output logic    active
);
    logic [CNT_W-1:0] remaining;
    logic [CNT_W-1:0] req_cnt;
    logic             nak_en;
    logic             issue;
    logic             accept;
    logic             on_last;

    assign req_cnt    = clamp_count(ctl_word.count, MAX_BURST);
    assign accept     = ctl_wr && !active && eng_idle;
    assign on_last    = (remaining == CNT_W'(1));
    assign eng_start  = issue;
    assign eng_cont   = (remaining > CNT_W'(1));
    assign eng_ack_en = !(nak_en && on_last);
    assign push       = byte_done;
    assign done_set   = (accept && (req_cnt == '0)) || (byte_done && on_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
            nak_en    <= 1'b0;
            issue     <= 1'b0;
            active    <= 1'b0;
        end else if (accept) begin
            remaining <= req_cnt;
            nak_en    <= ctl_word.nak_last;
            issue     <= (req_cnt != '0);
            active    <= (req_cnt != '0);
        end else if (active) begin
            issue <= 1'b0;
            if (byte_done) begin
                remaining <= remaining - CNT_W'(1);
                if (on_last) active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_burst_rx.sv
module i2c_burst_rx
    import i2c_brx_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int SCL_HALF   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_data,
    output logic       busy,
    input  logic       pop,
    output logic [7:0] pop_data,
    output logic       rx_empty,
    output logic       done_flag,
    input  logic       done_clr,
    input  logic       irq_en,
    output logic       irq,
    output logic       scl_o,
    output logic       sda_drive_low,
    input  logic       sda_i
);
    rx_ctl_t           ctl_word;
    logic              eng_idle, byte_done, eng_start, eng_cont, eng_ack_en;
    logic              push, done_set, active, fifo_full;
    logic [BYTE_W-1:0] byte_q;
    logic              done_q;

    assign ctl_word = rx_ctl_t'(ctl_data);

    i2c_brx_seq #(.MAX_BURST(FIFO_DEPTH)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .ctl_word   (ctl_word),
        .eng_idle   (eng_idle),
        .byte_done  (byte_done),
        .eng_start  (eng_start),
        .eng_cont   (eng_cont),
        .eng_ack_en (eng_ack_en),
        .push       (push),
        .done_set   (done_set),
        .active     (active)
    );

    i2c_brx_bit_eng #(.HALF(SCL_HALF)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (eng_start),
        .cont      (eng_cont),
        .ack_en    (eng_ack_en),
        .sda_i     (sda_i),
        .scl_o     (scl_o),
        .sda_low   (sda_drive_low),
        .byte_done (byte_done),
        .byte_q    (byte_q),
        .idle      (eng_idle)
    );

    i2c_brx_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (byte_q),
        .pop   (pop),
        .dout  (pop_data),
        .empty (rx_empty),
        .full  (fifo_full)
    );

    always_ff @(posedge clk) begin
        if (rst)           done_q <= 1'b0;
        else if (done_set) done_q <= 1'b1;
        else if (done_clr) done_q <= 1'b0;
    end

    assign done_flag = done_q;
    assign irq       = done_q && irq_en;
    assign busy      = active || !eng_idle;
endmodule

// File: rtl/i2c_burst_rx_chk.sv
module i2c_burst_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic [6:0] ctl_count,
    input logic       busy,
    input logic       done_flag,
    input logic       done_clr,
    input logic       scl_o,
    input logic       sda_drive_low
);
    // R1: bus released whenever no burst runs
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (scl_o && !sda_drive_low));

    // R3: SDA drive never moves during an SCL high phase
    a_r3_sda_steady_high: assert property (@(posedge clk) disable iff (rst)
        (scl_o && $past(scl_o)) |-> $stable(sda_drive_low));

    // R4: acknowledge drive only inside a burst
    a_r4_ack_in_burst: assert property (@(posedge clk) disable iff (rst)
        sda_drive_low |-> busy);

    // R2: a burst begins only after a control write
    a_r2_start_by_write: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ctl_wr));

    // R8: zero count completes on the accepting edge without going busy
    a_r8_zero_count: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !busy && (ctl_count == 7'd0)) |=> (done_flag && !busy));

    // R7: completion flag rises only through a burst or a write
    a_r7_done_source: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> ($past(busy) || $past(ctl_wr)));

    // R7: completion flag falls only through a clear
    a_r7_done_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(done_flag) |-> $past(done_clr));
endmodule

bind i2c_burst_rx i2c_burst_rx_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ctl_wr        (ctl_wr),
    .ctl_count     (ctl_data[6:0]),
    .busy          (busy),
    .done_flag     (done_flag),
    .done_clr      (done_clr),
    .scl_o         (scl_o),
    .sda_drive_low (sda_drive_low)
);

// File: tb/i2c_burst_rx_tb.sv
module i2c_burst_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    typedef struct packed {
        logic       nak;
        logic [6:0] cnt;
        logic [7:0] seed;
    } vec_t;

    localparam vec_t VEC [0:4] = '{
        '{1'b1, 7'd3, 8'h5A},
        '{1'b1, 7'd1, 8'hC3},
        '{1'b0, 7'd5, 8'h10},
        '{1'b0, 7'd2, 8'hFF},
        '{1'b1, 7'd4, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_data = 8'h00;
    logic       pop = 1'b0;
    logic       done_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       busy, rx_empty, done_flag, irq, scl_o, sda_drive_low, sda_i;
    logic [7:0] pop_data;

    int checks = 0;
    int errors = 0;

    i2c_burst_rx #(.FIFO_DEPTH(DEPTH), .SCL_HALF(4)) dut_i (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data), .busy(busy),
        .pop(pop), .pop_data(pop_data), .rx_empty(rx_empty), .done_flag(done_flag),
        .done_clr(done_clr), .irq_en(irq_en), .irq(irq), .scl_o(scl_o),
        .sda_drive_low(sda_drive_low), .sda_i(sda_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Target model: bytes seed + k*37, MSB first, one bit per SCL low phase.
    logic [7:0] seed = 8'h00;
    int         bitpos = 8;
    int         sidx = 0;
    int         negs = 0;
    logic       ack_log [0:127];
    logic       pscl = 1'b1;
    logic       pbusy = 1'b0;
    logic [7:0] cur_byte;

    function automatic logic [7:0] byte_of(input logic [7:0] sd, input int k);
        return sd + 8'(k * 37);
    endfunction

    assign cur_byte = byte_of(seed, sidx);
    assign sda_i    = (bitpos < 8) ? cur_byte[7 - bitpos] : 1'b1;

    always @(scl_o or busy) begin
        if (!rst) begin
            if (busy && !pbusy) begin
                bitpos = 8;
                sidx   = 0;
                negs   = 0;
            end
            if (pscl === 1'b1 && scl_o === 1'b0) begin
                negs   = negs + 1;
                bitpos = (bitpos == 8) ? 0 : bitpos + 1;
            end
            if (pscl === 1'b0 && scl_o === 1'b1 && bitpos == 8) begin
                ack_log[sidx] = sda_drive_low;
                sidx = sidx + 1;
            end
        end
        pscl  = scl_o;
        pbusy = busy;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic nak, input logic [6:0] cnt);
        @(negedge clk);
        ctl_wr   = 1'b1;
        ctl_data = {nak, cnt};
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic drain_check(input string req, input logic [7:0] sd, input int n);
        for (int k = 0; k < n; k++) begin
            chk(req, pop_data, byte_of(sd, k));
            do_pop();
        end
        chk(req, rx_empty, 1);
    endtask

    task automatic clear_done();
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 done_flag", done_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 scl_o", scl_o, 1);
        chk("R1 sda_drive_low", sda_drive_low, 0);

        // Table walk: R3 edge count, R4/R5 ack pattern, R6 order, R7 flag/irq
        for (int v = 0; v < 5; v++) begin
            int n;
            n      = int'(VEC[v].cnt);
            seed   = VEC[v].seed;
            irq_en = v[0];
            write_ctl(VEC[v].nak, VEC[v].cnt);
            wait_idle();
            chk("R3 scl falls", negs, 9 * n + 1);
            for (int k = 0; k < n; k++) begin
                int exp_ack;
                exp_ack = (VEC[v].nak && k == n - 1) ? 0 : 1;
                chk(VEC[v].nak ? "R4 ack slot" : "R5 ack slot", ack_log[k], exp_ack);
            end
            chk("R7 done set", done_flag, 1);
            chk("R7 irq", irq, v[0]);
            drain_check("R6 data order", VEC[v].seed, n);
            clear_done();
            chk("R7 done cleared", done_flag, 0);
        end
        irq_en = 1'b0;

        // R6 pop while empty has no effect
        do_pop();
        chk("R6 empty after pop", rx_empty, 1);
        seed = 8'h77;
        write_ctl(1'b1, 7'd1);
        wait_idle();
        chk("R6 first byte after empty pop", pop_data, 8'h77);
        do_pop();
        chk("R6 empty again", rx_empty, 1);
        clear_done();

        // R8 zero count
        snap = negs;
        @(negedge clk);
        ctl_wr   = 1'b1;
        ctl_data = 8'h80;
        @(negedge clk);
        ctl_wr = 1'b0;
        chk("R8 done on accept", done_flag, 1);
        chk("R8 not busy", busy, 0);
        repeat (20) @(negedge clk);
        chk("R8 no scl edges", negs, snap);
        chk("R8 fifo empty", rx_empty, 1);
        clear_done();

        // R2 clamp to 64, then R10 drop into full FIFO
        seed = 8'h01;
        write_ctl(1'b1, 7'd100);
        wait_idle();
        chk("R2 clamped scl falls", negs, 9 * DEPTH + 1);
        chk("R2 nak on byte 64", ack_log[DEPTH - 1], 0);
        chk("R2 ack on byte 63", ack_log[DEPTH - 2], 1);
        clear_done();
        seed = 8'hE0;
        write_ctl(1'b1, 7'd2);
        wait_idle();
        chk("R10 bus still clocked", negs, 19);
        chk("R10 still acks", ack_log[0], 1);
        drain_check("R10 only first burst kept", 8'h01, DEPTH);
        clear_done();

        // R9 write during busy ignored
        seed = 8'h31;
        write_ctl(1'b0, 7'd4);
        repeat (30) @(negedge clk);
        chk("R9 busy mid burst", busy, 1);
        write_ctl(1'b1, 7'd2);
        wait_idle();
        chk("R9 count kept", negs, 37);
        chk("R9 nak setting kept", ack_log[3], 1);
        drain_check("R9 bytes of first burst", 8'h31, 4);
        clear_done();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule